// File: doc/BRIEF.md
# Masked bit set/clear read-modify-write unit

This unit executes two 8-bit CPU instructions that use the accumulator as a bit mask on one memory byte. The set form ORs the mask into the byte. The clear form ANDs the byte with the complement of the mask. Both forms report a zero flag taken from the AND of the mask with the byte as it was before the change. The accumulator is never written.

The unit owns a byte-wide memory port for the length of one instruction. A one-cycle `start_i` pulse in idle hands over the opcode address and the accumulator value. The unit then fetches the opcode and one or two address bytes. It reads the target byte, spends one internal cycle forming the result, and writes the result back. In the write cycle it pulses the zero-flag update strobe and the done strobe and presents the address of the next instruction.

The memory port is single-cycle: the address and strobes are driven from registers, and the read data is sampled at the clock edge that ends the cycle in which the read was requested.

Top module: `bitmask_rmw`

## Requirements
- R1: After reset, and in every idle cycle, `mem_rd_o`, `mem_wr_o`, `z_we_o` and `done_o` are low.
- R2: A `start_i` pulse in idle latches `pc_i` and `acc_i`. In the next cycle the opcode is read from `pc_i`. Opcode bit 3 selects absolute (1) or zero-page (0) addressing, and bit 4 selects clear (1) or set (0). The four codes are 0x04, 0x0C, 0x14 and 0x1C.
- R3: Zero-page form: the address byte is read from opcode address + 1, and the target is {0x00, byte}. The instruction takes 5 cycles, from the opcode cycle to the write cycle inclusive.
- R4: Absolute form: the low address byte is read from opcode address + 1 and the high byte from + 2 (little-endian). The instruction takes 6 cycles.
- R5: The target is read in one cycle. The next cycle issues no memory request and keeps the target address. The cycle after that writes to the same address.
- R6: The set form writes original | mask.
- R7: The clear form writes original & ~mask.
- R8: `z_we_o` pulses only in the write cycle. With it, `z_o` is 1 exactly when mask & original byte is zero. The value written plays no part.
- R9: `done_o` is high in the write cycle only. In that cycle `next_pc_o` equals the opcode address + 2 (zero-page) or + 3 (absolute), modulo 2^16.
- R10: Once an instruction has started, changes on `acc_i` and further `start_i` pulses have no effect until it completes.
- R11: Each instruction performs exactly one write, in its final cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an instruction (honoured in idle only) |
| pc_i | input | 16 | Opcode address |
| acc_i | input | 8 | Accumulator value used as mask |
| mem_addr_o | output | 16 | Memory address |
| mem_rd_o | output | 1 | Read request |
| mem_wr_o | output | 1 | Write request |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, sampled at the end of a read cycle |
| z_o | output | 1 | Zero flag value |
| z_we_o | output | 1 | Zero flag update strobe |
| done_o | output | 1 | Final cycle of an instruction |
| next_pc_o | output | 16 | Address of the following instruction |

## Verification
The masks and bytes are chosen so that each outcome is reached by a different route:
- a zero mask, which leaves the byte unchanged and sets Z;
- an all-ones mask, which sets or clears every bit;
- a mask disjoint from the byte, which gives Z = 1 although a set leaves a nonzero byte;
- overlapping masks, which tell the two forms apart.

The addressing patterns cover the 16-bit wrap of the operand fetch and of the next address, and a zero-page target that is the instruction's own operand byte. A cycle-exact model also runs with `acc_i` changing and `start_i` held high while an instruction is in flight, which shows that both inputs are latched once.

// File: rtl/bitmask_rmw_pkg.sv
package bitmask_rmw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADL,
    ST_ADH,
    ST_RD,
    ST_MOD,
    ST_WR
  } bmr_state_e;

  localparam int OP_ABS_BIT = 3;
  localparam int OP_CLR_BIT = 4;
  localparam int ZP_LEN     = 2;
  localparam int ABS_LEN    = 3;
endpackage

// File: rtl/bmr_seq.sv
module bmr_seq
  import bitmask_rmw_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       abs_i,
  output bmr_state_e state_o
);
  bmr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_OPC;
      ST_OPC:  state_d = ST_ADL;
      ST_ADL:  state_d = abs_i ? ST_ADH : ST_RD;
      ST_ADH:  state_d = ST_RD;
      ST_RD:   state_d = ST_MOD;
      ST_MOD:  state_d = ST_WR;
      ST_WR:   state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // R10
  busy_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != ST_IDLE |=> state_q != ST_OPC);

  // R5
  rd_then_mod_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_RD |=> state_q == ST_MOD);
endmodule

// File: rtl/bmr_capture.sv
module bmr_capture
  import bitmask_rmw_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bmr_state_e        state_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] acc_o,
  output logic              abs_o,
  output logic              clr_o,
  output logic [ADDR_W-1:0] target_o,
  output logic [DATA_W-1:0] orig_o
);
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] acc_q, adl_q, adh_q, orig_q;
  logic              abs_q, clr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      acc_q  <= '0;
      adl_q  <= '0;
      adh_q  <= '0;
      orig_q <= '0;
      abs_q  <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      unique case (state_i)
        ST_IDLE: if (start_i) begin
          pc_q  <= pc_i;
          acc_q <= acc_i;
        end
        ST_OPC: begin
          abs_q <= rdata_i[OP_ABS_BIT];
          clr_q <= rdata_i[OP_CLR_BIT];
          adh_q <= '0;  // zero page
        end
        ST_ADL:  adl_q  <= rdata_i;
        ST_ADH:  adh_q  <= rdata_i;
        ST_RD:   orig_q <= rdata_i;
        default: ;
      endcase
    end
  end

  assign pc_o     = pc_q;
  assign acc_o    = acc_q;
  assign abs_o    = abs_q;
  assign clr_o    = clr_q;
  assign target_o = {adh_q, adl_q};
  assign orig_o   = orig_q;

  // R10
  acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i inside {ST_ADL, ST_ADH, ST_RD, ST_MOD, ST_WR}) |-> $stable(acc_q));

  // R10
  pc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i inside {ST_ADL, ST_ADH, ST_RD, ST_MOD, ST_WR}) |-> $stable(pc_q));
endmodule

// File: rtl/bmr_modify.sv
module bmr_modify #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] orig_i,
  output logic [DATA_W-1:0] result_o,
  output logic              zero_o
);
  logic [DATA_W-1:0] res_d, res_q;
  logic              zero_q;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign res_d[b] = clr_i ? (orig_i[b] & ~acc_i[b]) : (orig_i[b] | acc_i[b]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= '0;
      zero_q <= 1'b0;
    end else if (load_i) begin
      res_q  <= res_d;
      zero_q <= ~|(acc_i & orig_i);  // flag from unmodified byte
    end
  end

  assign result_o = res_q;
  assign zero_o   = zero_q;

  // R6
  set_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !clr_i |=> ((result_o & $past(acc_i)) == $past(acc_i)) &&
                         ((result_o & ~$past(acc_i)) == ($past(orig_i) & ~$past(acc_i))));

  // R7
  clr_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && clr_i |=> ((result_o & $past(acc_i)) == '0) &&
                        ((result_o & ~$past(acc_i)) == ($past(orig_i) & ~$past(acc_i))));

  // R8
  zero_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && ((acc_i & orig_i) != '0) |=> !zero_o);
endmodule

// File: rtl/bitmask_rmw.sv
module bitmask_rmw
  import bitmask_rmw_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] acc_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              z_o,
  output logic              z_we_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] next_pc_o
);
  bmr_state_e        state;
  logic [ADDR_W-1:0] pc, target;
  logic [DATA_W-1:0] acc, orig, result;
  logic              is_abs, is_clr, zero;

  bmr_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .abs_i   (is_abs),
    .state_o (state)
  );

  bmr_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .state_i  (state),
    .start_i  (start_i),
    .pc_i     (pc_i),
    .acc_i    (acc_i),
    .rdata_i  (mem_rdata_i),
    .pc_o     (pc),
    .acc_o    (acc),
    .abs_o    (is_abs),
    .clr_o    (is_clr),
    .target_o (target),
    .orig_o   (orig)
  );

  bmr_modify #(.DATA_W(DATA_W)) u_mod (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (state == ST_MOD),
    .clr_i    (is_clr),
    .acc_i    (acc),
    .orig_i   (orig),
    .result_o (result),
    .zero_o   (zero)
  );

  always_comb begin
    unique case (state)
      ST_OPC:                mem_addr_o = pc;
      ST_ADL:                mem_addr_o = pc + ADDR_W'(1);
      ST_ADH:                mem_addr_o = pc + ADDR_W'(2);
      ST_RD, ST_MOD, ST_WR:  mem_addr_o = target;
      default:               mem_addr_o = '0;
    endcase
  end

  assign mem_rd_o    = state inside {ST_OPC, ST_ADL, ST_ADH, ST_RD};
  assign mem_wr_o    = (state == ST_WR);
  assign mem_wdata_o = mem_wr_o ? result : '0;
  assign z_we_o      = mem_wr_o;
  assign z_o         = mem_wr_o & zero;
  assign done_o      = mem_wr_o;
  assign next_pc_o   = pc + (is_abs ? ADDR_W'(ABS_LEN) : ADDR_W'(ZP_LEN));

  // cycle count since opcode cycle, checker use
  logic [2:0] span_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               span_q <= '0;
    else if (state == ST_IDLE) span_q <= '0;
    else                       span_q <= span_q + 3'd1;
  end

  // R3
  zp_span_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !is_abs |-> span_q == 3'd4);

  // R4
  abs_span_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && is_abs |-> span_q == 3'd5);

  // R5
  same_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> (mem_addr_o == $past(mem_addr_o, 2)) && $past(mem_rd_o, 2) && !$past(mem_rd_o));

  // R11
  single_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |=> !mem_wr_o && !mem_rd_o);

  // R1
  quiet_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !mem_rd_o && !mem_wr_o && !done_o);
endmodule

// File: tb/test_bitmask_rmw.sv
module test_bitmask_rmw;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] pc_i = '0;
  logic [7:0]  acc_i = '0;
  logic [15:0] mem_addr_o;
  logic        mem_rd_o, mem_wr_o;
  logic [7:0]  mem_wdata_o;
  logic [7:0]  mem_rdata_i = '0;
  logic        z_o, z_we_o, done_o;
  logic [15:0] next_pc_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bitmask_rmw i_bitmask_rmw (
    .clk_i, .rst_ni, .start_i, .pc_i, .acc_i,
    .mem_addr_o, .mem_rd_o, .mem_wr_o, .mem_wdata_o, .mem_rdata_i,
    .z_o, .z_we_o, .done_o, .next_pc_o
  );

  typedef struct {
    logic [15:0] addr;
    logic        rd;
    logic        wr;
    logic [7:0]  wd;
    logic        z;
    logic [15:0] npc;
    string       atag;
    string       wtag;
  } exp_t;

  exp_t        exp_q[$];
  logic [7:0]  mem_q [logic [15:0]];
  int          vectors = 0;
  int          miscompares = 0;
  bit          reported = 0;

  function automatic logic [7:0] rd_mem(input logic [15:0] a);
    if (mem_q.exists(a)) return mem_q[a];
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic void cmp(input string req, input string what,
                              input logic [15:0] act, input logic [15:0] expv,
                              inout bit bad);
    if (act !== expv) begin
      $display("FAIL %s %s: got %h expected %h at %0t", req, what, act, expv, $time);
      bad = 1;
    end
  endfunction

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  // compare current cycle, then answer the memory port
  task automatic check();
    bit bad = 0;
    vectors++;
    if (exp_q.size() == 0) begin
      cmp("R1", "rd", 16'(mem_rd_o), 16'd0, bad);
      cmp("R11", "wr", 16'(mem_wr_o), 16'd0, bad);
      cmp("R8", "z_we", 16'(z_we_o), 16'd0, bad);
      cmp("R9", "done", 16'(done_o), 16'd0, bad);
    end else begin
      exp_t e = exp_q.pop_front();
      cmp(e.atag, "addr", mem_addr_o, e.addr, bad);
      cmp(e.atag, "rd", 16'(mem_rd_o), 16'(e.rd), bad);
      cmp("R11", "wr", 16'(mem_wr_o), 16'(e.wr), bad);
      cmp("R8", "z_we", 16'(z_we_o), 16'(e.wr), bad);
      cmp("R9", "done", 16'(done_o), 16'(e.wr), bad);
      if (e.wr) begin
        cmp(e.wtag, "wdata", 16'(mem_wdata_o), 16'(e.wd), bad);
        cmp("R8", "z", 16'(z_o), 16'(e.z), bad);
        cmp("R9", "next_pc", next_pc_o, e.npc, bad);
        mem_q[e.addr] = e.wd;
      end
    end
    if (bad) miscompares++;
    mem_rdata_i = rd_mem(mem_addr_o);
  endtask

  task automatic tick(input logic st, input logic [15:0] pc, input logic [7:0] a);
    @(negedge clk_i);
    check();
    start_i = st;
    pc_i    = pc;
    acc_i   = a;
  endtask

  function automatic void push(input logic [15:0] addr, input logic rd, input logic wr,
                               input logic [7:0] wd, input logic z, input logic [15:0] npc,
                               input string atag, input string wtag);
    exp_t e;
    e.addr = addr; e.rd = rd; e.wr = wr; e.wd = wd; e.z = z; e.npc = npc;
    e.atag = atag; e.wtag = wtag;
    exp_q.push_back(e);
  endfunction

  task automatic run(input logic [15:0] pc, input logic [7:0] op, input logic [7:0] acc,
                     input logic [15:0] tgt, input logic [7:0] orig, input bit noise);
    logic        is_abs = op[3];
    logic        is_clr = op[4];
    logic [15:0] p1 = pc + 16'd1;
    logic [15:0] p2 = pc + 16'd2;
    logic [7:0]  o, wd;
    logic        z;
    logic [15:0] npc;
    int          n;
    mem_q[tgt] = orig;
    mem_q[pc]  = op;
    mem_q[p1]  = tgt[7:0];
    if (is_abs) mem_q[p2] = tgt[15:8];
    tick(1'b1, pc, acc);
    o   = rd_mem(tgt);
    wd  = is_clr ? (o & ~acc) : (o | acc);
    z   = ((acc & o) == 8'h00);
    npc = pc + (is_abs ? 16'd3 : 16'd2);
    push(pc, 1, 0, 0, 0, 0, "R2", "");
    push(p1, 1, 0, 0, 0, 0, is_abs ? "R4" : "R3", "");
    if (is_abs) push(p2, 1, 0, 0, 0, 0, "R4", "");
    push(tgt, 1, 0, 0, 0, 0, "R5", "");
    push(tgt, 0, 0, 0, 0, 0, "R5", "");
    push(tgt, 0, 1, wd, z, npc, "R5", is_clr ? "R7" : "R6");
    n = is_abs ? 6 : 5;
    // R10: mask input changes every cycle, start held when noise is set
    for (int i = 0; i < n; i++)
      tick(noise, noise ? 16'hBEEF : 16'h0000, ~acc ^ 8'(i * 37));
    tick(1'b0, 16'h0000, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    $display("FAIL watchdog expired");
    miscompares++;
    report();
  end

  initial begin
    // R1: quiet during and right after reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      check();
    end
    rst_ni = 1'b1;
    for (int i = 0; i < 2; i++) tick(1'b0, 16'h0000, 8'h00);

    run(16'h0200, 8'h04, 8'h81, 16'h0040, 8'h14, 0); // R6 zp set
    run(16'h0210, 8'h14, 8'h0F, 16'h0041, 8'h3C, 0); // R7 zp clr -> 30
    run(16'h0300, 8'h0C, 8'h00, 16'h4567, 8'hA5, 0); // R4 zero mask, Z=1
    run(16'h0310, 8'h1C, 8'hFF, 16'h8001, 8'hA5, 0); // R7 full clear
    run(16'h0320, 8'h0C, 8'hFF, 16'h8002, 8'h00, 0); // R6 full set
    run(16'h0330, 8'h04, 8'hF0, 16'h0050, 8'h0F, 0); // R8 Z from original
    run(16'h0340, 8'h14, 8'h0F, 16'h0051, 8'hF0, 0); // R8 disjoint clear
    run(16'hFFFE, 8'h0C, 8'h3C, 16'h1234, 8'h55, 0); // R4 R9 wrap
    run(16'hFFFF, 8'h14, 8'h01, 16'h00FF, 8'h03, 0); // R3 R9 wrap
    run(16'h0010, 8'h04, 8'h80, 16'h0011, 8'h00, 0); // R5 target is own operand
    run(16'h0400, 8'h1C, 8'h5A, 16'h2222, 8'hFF, 1); // R10 noise
    run(16'h0410, 8'h04, 8'h24, 16'h0099, 8'h42, 1); // R10 noise zp

    for (int i = 0; i < 24; i++) begin : sweep
      logic [7:0]  op  = 8'h04 | (i[0] ? 8'h08 : 8'h00) | (i[1] ? 8'h10 : 8'h00);
      logic [15:0] tgt = op[3] ? 16'(i * 4099 + 7) : {8'h00, 8'(i * 29 + 3)};
      run(16'(16'h1000 + i * 977), op, 8'(i * 53 + 1), tgt, 8'(i * 91 + 5), i[2]);
    end

    report();
  end
endmodule